// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a write-only two-wire serial slave that holds the clock-control configuration of a clock generator. It oversamples the serial clock and data lines with the system clock, recognises START and STOP conditions, and compares the first byte of each transfer with a fixed 7-bit address. The serial data line is modelled as an open-drain wire: the block only pulls it low to acknowledge.

A transfer carries a sequence of data bytes, most significant bit first. The first four data bytes are acknowledged and dropped. The next three bytes load three configuration registers: one enable byte for the processor, auxiliary-bus, peripheral-serial and reference outputs; one enable byte for the PCI and second reference outputs; and a control byte. The control byte holds the output mode code, the register-over-pin mode selector and the memory-clock enable. Any further bytes are acknowledged and dropped. A register is written only once all eight bits of its byte have arrived.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset `core_en_o` is 8'hFF, `bus_en_o` is 8'hFF and `gen_ctl_o` is 8'h7D (bit 7 = 0, bits 6..2 = 1, bit 1 = 0, bit 0 = 1); `sda_pull_o` is low.
- R2: A first byte of 8'hD2 (address 7'b1101001 followed by write bit 0) is acknowledged by holding `sda_pull_o` high through the ninth SCL high phase, which is then released.
- R3: A first byte with a different address, or with the read bit (8'hD3), is not acknowledged; no byte of that transfer is acknowledged or stored until the next START.
- R4: Each byte is shifted in most significant bit first, so bit 7 is the first bit on the line.
- R5: Data bytes with index 0 to 3 (counting from the first byte after the address) are acknowledged and change no register.
- R6: Data byte 4 is stored in `core_en_o`, bit 7 down to bit 0 enabling REF0, USB/IO, USB0, AGP1, AGP0, CPU2, CPU1, CPU0; 1 means the output runs.
- R7: Data byte 5 is stored in `bus_en_o`, bit 7 enabling REF1 and bits 6..0 enabling PCI outputs 6..0.
- R8: Data byte 6 is stored in `gen_ctl_o`; `mode_code_o` equals its bits 6..4 (test, select 1, select 0), `reg_mode_o` its bit 7 and `sdram_en_o` its bit 0.
- R9: Data bytes after index 6 are acknowledged and change no register.
- R10: A STOP or a repeated START returns the byte index to 0 for the following transfer.
- R11: A register changes only when a complete eight-bit byte has been received, at the SCL fall ending its eighth bit; a byte cut short by a STOP changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| core_en_o | output | 8 | Enable byte for reference 0, serial-bus, auxiliary and processor outputs |
| bus_en_o | output | 8 | Enable byte for reference 1 and PCI outputs |
| gen_ctl_o | output | 8 | Control byte |
| mode_code_o | output | 3 | Frequency/test mode code |
| reg_mode_o | output | 1 | 1 selects register-based over pin-based mode control |
| sdram_en_o | output | 1 | Memory clock output enable |

## Verification
The assertions take for granted that SCL stays low, after each falling edge, for longer than the two-stage synchronizer plus edge detector needs, and that SDA moves only while SCL is low except for START and STOP. Under that assumption the acknowledge never moves while SCL is high and every register update falls inside an acknowledge low phase. The bench keeps every line phase ten system clocks long and changes SDA only in the SCL low phase, apart from the explicit START, repeated START and STOP sequences.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/smb_rx_fsm.sv
module smb_rx_fsm
  import smb_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter logic [6:0]  SLAVE_ADDR = 7'b1101001,
  parameter int          CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              ack_o,
  output logic              wr_stb,
  output logic [CNT_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] FULL = BIT_W'(BYTE_W);

  rx_state_e          state;
  logic [BIT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  shreg;
  logic [CNT_W-1:0]   byte_cnt;
  logic               addr_hit;

  assign addr_hit = (shreg[BYTE_W-1 -: ADDR_W] == SLAVE_ADDR) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_cnt <= '0;
      ack_o    <= 1'b0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ack_o    <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ack_o    <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_q};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == FULL) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  ack_o <= 1'b1;
                  state <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                ack_o   <= 1'b1;
                state   <= ST_DATA_ACK;
                wr_stb  <= 1'b1;
                wr_idx  <= byte_cnt;
                wr_data <= shreg;
                if (byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              ack_o   <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
  import smb_cfg_pkg::*;
#(
  parameter int                         NUM_REGS  = 3,
  parameter int                         FIRST_IDX = 4,
  parameter int                         CNT_W     = 4,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS  = 24'h7D_FF_FF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_stb,
  input  logic [CNT_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [NUM_REGS*BYTE_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [CNT_W-1:0] MY_IDX = CNT_W'(FIRST_IDX + g);
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[g*BYTE_W +: BYTE_W] <= DEFAULTS[g*BYTE_W +: BYTE_W];
      else if (wr_stb && wr_idx == MY_IDX)
        regs_o[g*BYTE_W +: BYTE_W] <= wr_data;
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = 7'b1101001,
  parameter int         SKIP_BYTES  = 4,
  parameter int         CNT_W       = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic [7:0]  core_en_o,
  output logic [7:0]  bus_en_o,
  output logic [7:0]  gen_ctl_o,
  output logic [2:0]  mode_code_o,
  output logic        reg_mode_o,
  output logic        sdram_en_o
);
  localparam int NUM_REGS = 3;
  localparam logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = {8'h7D, 8'hFF, 8'hFF};

  logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb;
  logic [CNT_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [NUM_REGS*BYTE_W-1:0] regs;

  smb_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_rx_fsm #(.ADDR_W(7), .SLAVE_ADDR(SLAVE_ADDR), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_o(sda_pull_o), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  smb_cfg_bank #(
    .NUM_REGS(NUM_REGS), .FIRST_IDX(SKIP_BYTES), .CNT_W(CNT_W), .DEFAULTS(DEFAULTS)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs)
  );

  assign core_en_o   = regs[7:0];
  assign bus_en_o    = regs[15:8];
  assign gen_ctl_o   = regs[23:16];
  assign mode_code_o = regs[22:20];
  assign reg_mode_o  = regs[23];
  assign sdram_en_o  = regs[16];
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic [7:0] core_en_o,
  input logic [7:0] bus_en_o,
  input logic [7:0] gen_ctl_o
);
  a_r1_reset_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (core_en_o == 8'hFF && bus_en_o == 8'hFF &&
                    gen_ctl_o == 8'h7D && !sda_pull_o));

  a_r2_ack_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

  a_r2_ack_begins_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i);

  a_r11_update_inside_ack: assert property (@(posedge clk) disable iff (rst)
    !$stable({core_en_o, bus_en_o, gen_ctl_o}) |-> (sda_pull_o && !scl_i));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .core_en_o(core_en_o), .bus_en_o(bus_en_o), .gen_ctl_o(gen_ctl_o)
);

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull_o;
  logic [7:0] core_en_o, bus_en_o, gen_ctl_o;
  logic [2:0] mode_code_o;
  logic reg_mode_o, sdram_en_o;
  wire  sda_line = m_sda & ~sda_pull_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_a = 8'hFF, exp_b = 8'hFF, exp_c = 8'h7D;
  logic [7:0] txq [0:15];

  always #10 clk = ~clk;

  smb_cfg_slave u_smb_cfg_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .core_en_o(core_en_o), .bus_en_o(bus_en_o),
    .gen_ctl_o(gen_ctl_o), .mode_code_o(mode_code_o),
    .reg_mode_o(reg_mode_o), .sdram_en_o(sdram_en_o)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    m_sda = 1'b1; wq(); m_scl = 1'b1;
    repeat (Q/2) @(negedge clk);
    acked = (sda_line == 1'b0);
    repeat (Q/2) @(negedge clk);
    m_scl = 1'b0; wq();
  endtask

  // send txq[0..n-1] as data bytes after a write address; model expectations
  task automatic write_txn(input int n, input string req);
    logic ak;
    bus_start();
    send_byte(8'hD2, ak);
    chk(ak, "R2", {7'd0, ak}, 8'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(txq[i], ak);
      chk(ak, (i > 6) ? "R9" : req, {7'd0, ak}, 8'd1);
      if (i == 4) exp_a = txq[i];
      if (i == 5) exp_b = txq[i];
      if (i == 6) exp_c = txq[i];
    end
    bus_stop();
  endtask

  task automatic check_regs(input string req);
    chk(core_en_o == exp_a, req, core_en_o, exp_a);
    chk(bus_en_o  == exp_b, req, bus_en_o, exp_b);
    chk(gen_ctl_o == exp_c, req, gen_ctl_o, exp_c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ak;
    repeat (8) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset values
    check_regs("R1");
    chk(sda_pull_o == 1'b0, "R1", {7'd0, sda_pull_o}, 8'd0);
    chk(mode_code_o == 3'b111 && !reg_mode_o && sdram_en_o, "R1",
        {3'd0, mode_code_o, reg_mode_o, sdram_en_o}, 8'b0001_1101);

    // R5: four leading bytes acknowledged, no register change
    for (int i = 0; i < 4; i++) txq[i] = 8'h11 * (i + 1);
    write_txn(4, "R5");
    check_regs("R5");
    chk(sda_pull_o == 1'b0, "R2", {7'd0, sda_pull_o}, 8'd0);

    // R3: wrong address and read request
    for (int a = 0; a < 2; a++) begin
      bus_start();
      send_byte(a == 0 ? 8'hA4 : 8'hD3, ak);
      chk(!ak, "R3", {7'd0, ak}, 8'd0);
      for (int i = 0; i < 7; i++) begin
        send_byte(8'h0F + 8'(i), ak);
        chk(!ak, "R3", {7'd0, ak}, 8'd0);
      end
      bus_stop();
      check_regs("R3");
    end

    // sweep of patterns, with two trailing bytes (R9)
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 4; i++) txq[i] = 8'(k * 13 + i);
      txq[4] = 8'(k * 17) ^ 8'h5A;
      txq[5] = ~8'(k * 29);
      txq[6] = 8'(k * 37 + 3);
      txq[7] = 8'hC3;
      txq[8] = 8'h3C;
      write_txn(9, "R5");
      chk(core_en_o == exp_a, "R6", core_en_o, exp_a);
      chk(bus_en_o  == exp_b, "R7", bus_en_o, exp_b);
      chk(gen_ctl_o == exp_c, "R8", gen_ctl_o, exp_c);
      chk(mode_code_o == exp_c[6:4] && reg_mode_o == exp_c[7] && sdram_en_o == exp_c[0],
          "R8", {3'd0, mode_code_o, reg_mode_o, sdram_en_o},
          {3'd0, exp_c[6:4], exp_c[7], exp_c[0]});
      check_regs("R9");
    end

    // R4: asymmetric byte proves MSB-first order
    for (int i = 0; i < 4; i++) txq[i] = 8'h00;
    txq[4] = 8'h01; txq[5] = 8'h80; txq[6] = 8'h06;
    write_txn(7, "R5");
    chk(core_en_o == 8'h01, "R4", core_en_o, 8'h01);
    chk(bus_en_o == 8'h80, "R4", bus_en_o, 8'h80);

    // R10: repeated START restarts the byte index
    bus_start();
    send_byte(8'hD2, ak);
    send_byte(8'hE1, ak);
    send_byte(8'hE2, ak);
    bus_start();
    send_byte(8'hD2, ak);
    chk(ak, "R10", {7'd0, ak}, 8'd1);
    for (int i = 0; i < 4; i++) send_byte(8'h99, ak);
    send_byte(8'h3C, ak);
    bus_stop();
    exp_a = 8'h3C;
    check_regs("R10");

    // R10: STOP restarts the byte index
    bus_start();
    send_byte(8'hD2, ak);
    for (int i = 0; i < 3; i++) send_byte(8'h77, ak);
    bus_stop();
    check_regs("R10");
    for (int i = 0; i < 4; i++) txq[i] = 8'h44;
    txq[4] = 8'hA5;
    write_txn(5, "R10");
    check_regs("R10");

    // R11: partial byte cut by STOP changes nothing
    for (int p = 1; p < 8; p++) begin
      bus_start();
      send_byte(8'hD2, ak);
      for (int i = 0; i < 4; i++) send_byte(8'h00, ak);
      send_bits(8'h00, p);
      bus_stop();
      chk(core_en_o == exp_a, "R11", core_en_o, exp_a);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule